// File: doc/BRIEF.md
# Auto Trigger Source Selector

This block decides when an analog-to-digital converter starts a conversion on its own. A 3-bit select code picks one of eight level sources. Seven of them are interrupt-flag levels from neighbouring peripherals. The eighth is the converter's own completion flag, used for free-running operation. The block watches the chosen level and issues a one-cycle start pulse on each rising edge of it. The pulse is issued only while both the auto-trigger enable and the converter enable are high.

Edge detection sits behind the source multiplexer. Changing the select from a source whose flag is low to one whose flag is high therefore looks like a rising edge and starts a conversion. Changing the select into free-running mode never starts a conversion by itself. In that case the stored history bit is forced high, so a completion flag that is already set cannot look like an edge.

The select code is held in a register inside the block. It is loaded through a simple write strobe and is visible on an output.

Top module: `auto_trig_sel`

## Requirements
- R1: The select code maps to the source as follows: 0 is the completion flag `doneFlag` (free running). Each code k from 1 to 7 is `srcFlags[k-1]`, where bit 0 is the comparator, bit 1 is external interrupt 0, bit 2 is timer0 compare A, bit 3 is timer0 overflow, bit 4 is timer1 compare B, bit 5 is timer1 overflow and bit 6 is timer1 capture.
- R2: While `rstN` is low and after its release, the select code is 0 and the edge history bit is 1. A completion flag that is high at reset release therefore gives no pulse.
- R3: `startPulse` is high in the same cycle that the selected level is 1 while its value sampled at the previous clock edge was 0, provided both `autoEn` and `convEn` are high.
- R4: A selected level that stays high yields exactly one pulse cycle.
- R5: Activity on sources that are not selected has no effect on `startPulse`.
- R6: While `autoEn` or `convEn` is low, `startPulse` stays low.
- R7: A select write takes effect at the next clock edge. `selOut` shows the new code from then on.
- R8: Writing a new code whose source is high, when the previous source was low, gives a pulse in the cycle after the write (if both enables are high).
- R9: Writing code 0 while another code is active forces the history bit high, so no pulse follows even if `doneFlag` is already high.
- R10: In free-running mode, each rising edge of `doneFlag` gives a pulse.
- R11: The edge history is updated every cycle, even while the enables are low. A level that rose while disabled gives no pulse when the enables are set later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selWrite | input | 1 | Load strobe for the select code |
| selData | input | 3 | New select code |
| srcFlags | input | 7 | Peripheral flag levels, ordered as in R1 |
| doneFlag | input | 1 | Converter completion flag level |
| autoEn | input | 1 | Auto-trigger enable |
| convEn | input | 1 | Converter enable |
| startPulse | output | 1 | One-cycle conversion start |
| selOut | output | 3 | Current select code |

## Verification
The bench builds the block with its default of seven peripheral sources, so the select field is 3 bits wide and every one of the eight codes can be reached. At this width, a directed sweep can select each source in turn and give it an edge. The sweep can also reach the paths that matter most at this size: a switch from a low source to a high one, and a switch into free running while the completion flag is high. A random phase then mixes select writes, flag toggles and enable changes, and a behavioural model is compared against the block on every cycle.

// File: rtl/ats_pkg.sv
package ats_pkg;
  localparam int unsigned NUM_PERIPH = 7;
  localparam int unsigned NUM_CODES = NUM_PERIPH + 1;
  localparam int unsigned SEL_W = $clog2(NUM_CODES);

  typedef enum logic [SEL_W-1:0] {
    SEL_FREE_RUN = 3'd0,
    SEL_COMPARE  = 3'd1,
    SEL_EXT_INT0 = 3'd2,
    SEL_T0_CMPA  = 3'd3,
    SEL_T0_OVF   = 3'd4,
    SEL_T1_CMPB  = 3'd5,
    SEL_T1_OVF   = 3'd6,
    SEL_T1_CAPT  = 3'd7
  } trigSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [SEL_W-1:0] selCode;
    logic fireAllowed;
    logic forceHistHigh;
  } ctrlStrobes_t;
endpackage

// File: rtl/ats_ctrl.sv
module ats_ctrl
  import ats_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic selWrite,
  input  logic [SW-1:0] selData,
  input  logic autoEn,
  input  logic convEn,
  output ctrlStrobes_t strobes
);
  logic [SW-1:0] selReg;
  logic enterFreeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selReg <= '0;
    else if (selWrite) selReg <= selData;
  end

  // entering free running from another code: history must read high
  assign enterFreeRun = selWrite && (selData == SW'(SEL_FREE_RUN)) &&
                        (selReg != SW'(SEL_FREE_RUN));

  always_comb begin
    strobes.selCode = selReg;
    strobes.fireAllowed = autoEn & convEn;
    strobes.forceHistHigh = enterFreeRun;
  end
endmodule

// File: rtl/ats_datapath.sv
module ats_datapath
  import ats_pkg::*;
#(
  parameter int unsigned NP = NUM_PERIPH
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic [NP-1:0] srcFlags,
  input  logic doneFlag,
  output logic startPulse
);
  localparam int unsigned NC = NP + 1;
  localparam int unsigned SW = $clog2(NC);

  logic [NC-1:0] srcAll;
  logic [NC-1:0] hit;
  logic muxed;
  logic histReg;

  assign srcAll = {srcFlags, doneFlag};

  for (genvar i = 0; i < NC; i++) begin : g_mux
    assign hit[i] = (strobes.selCode == SW'(i)) & srcAll[i];
  end
  assign muxed = |hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histReg <= 1'b1;
    else if (strobes.forceHistHigh) histReg <= 1'b1;
    else histReg <= muxed;
  end

  assign startPulse = strobes.fireAllowed & muxed & ~histReg;
endmodule

// File: rtl/auto_trig_sel.sv
module auto_trig_sel
  import ats_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic selWrite,
  input  logic [SEL_W-1:0] selData,
  input  logic [NUM_PERIPH-1:0] srcFlags,
  input  logic doneFlag,
  input  logic autoEn,
  input  logic convEn,
  output logic startPulse,
  output logic [SEL_W-1:0] selOut
);
  ctrlStrobes_t strobes;

  ats_ctrl #(.SW(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selWrite(selWrite), .selData(selData),
    .autoEn(autoEn), .convEn(convEn), .strobes(strobes)
  );

  ats_datapath #(.NP(NUM_PERIPH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcFlags(srcFlags),
    .doneFlag(doneFlag), .startPulse(startPulse)
  );

  assign selOut = strobes.selCode;
endmodule

// File: rtl/ats_checker.sv
module ats_checker
  import ats_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic selWrite,
  input logic [SEL_W-1:0] selData,
  input logic [NUM_PERIPH-1:0] srcFlags,
  input logic doneFlag,
  input logic autoEn,
  input logic convEn,
  input logic startPulse,
  input logic [SEL_W-1:0] selOut
);
  logic [NUM_CODES-1:0] allSrc;
  assign allSrc = {srcFlags, doneFlag};

  assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_enables_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (autoEn && convEn));

  assert_pulse_on_selected_R3: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> allSrc[selOut]);

  assert_free_run_switch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && selData == '0 && selOut != '0) |=> !startPulse);

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !selWrite |=> $stable(selOut));

  assert_sel_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    selWrite |=> (selOut == $past(selData)));
endmodule

bind auto_trig_sel ats_checker u_chk (
  .clk(clk), .rstN(rstN), .selWrite(selWrite), .selData(selData),
  .srcFlags(srcFlags), .doneFlag(doneFlag), .autoEn(autoEn), .convEn(convEn),
  .startPulse(startPulse), .selOut(selOut)
);

// File: tb/tb_auto_trig_sel.sv
`timescale 1ns/100ps
module tb_auto_trig_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selWrite = 1'b0;
  logic [2:0] selData = '0;
  logic [6:0] srcFlags = '0;
  logic doneFlag = 1'b0;
  logic autoEn = 1'b0;
  logic convEn = 1'b0;
  logic startPulse;
  logic [2:0] selOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [2:0] mSel;
  logic mPrev;

  always #2.5 clk = ~clk;

  auto_trig_sel dut (.*);

  function automatic logic pick(input logic [2:0] s);
    if (s == 3'd0) return doneFlag;
    return srcFlags[s - 3'd1];
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // call after inputs are set, just after a falling edge
  task automatic cycle(input string req);
    logic expStart;
    #1;
    expStart = autoEn & convEn & pick(mSel) & ~mPrev;
    check({req, " startPulse"}, {2'b0, startPulse}, {2'b0, expStart});
    check({req, " selOut"}, selOut, mSel);
    @(posedge clk);
    if (selWrite && selData == 3'd0 && mSel != 3'd0) mPrev = 1'b1;
    else mPrev = pick(mSel);
    if (selWrite) mSel = selData;
    @(negedge clk);
  endtask

  task automatic writeSel(input logic [2:0] code, input string req);
    selWrite = 1'b1; selData = code;
    cycle(req);
    selWrite = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mSel = '0; mPrev = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset sel", selOut, 3'd0);
    check("R2 reset pulse", {2'b0, startPulse}, 3'd0);
    doneFlag = 1'b1; autoEn = 1'b1; convEn = 1'b1;
    rstN = 1'b1;
    cycle("R2 done high at release");
    doneFlag = 1'b0; cycle("R10 low");
    doneFlag = 1'b1; cycle("R10 edge");
    cycle("R4 held high");
    cycle("R4 held high 2");
    doneFlag = 1'b0; cycle("R10 low");
    doneFlag = 1'b1; cycle("R10 second edge");
    doneFlag = 1'b0;
    srcFlags = 7'h7f; cycle("R5 unselected high");
    srcFlags = '0; cycle("R5 unselected low");

    // sweep every peripheral code
    for (int k = 1; k < 8; k++) begin
      writeSel(3'(k), "R7 write");
      cycle("R7 after write");
      srcFlags[k-1] = 1'b1; cycle("R1 R3 selected edge");
      cycle("R4 hold");
      srcFlags = 7'h7f & ~(7'h1 << (k-1)); cycle("R5 others");
      srcFlags = '0; cycle("R5 quiet");
    end

    // enables
    writeSel(3'd2, "R7 write");
    autoEn = 1'b0; srcFlags[1] = 1'b1; cycle("R6 autoEn low");
    autoEn = 1'b1; cycle("R11 enabled later");
    srcFlags = '0; convEn = 1'b0; cycle("R6 setup");
    srcFlags[1] = 1'b1; cycle("R6 convEn low");
    convEn = 1'b1; cycle("R11 convEn later");
    srcFlags = '0; cycle("R11 clear");

    // switch from low source to high source
    writeSel(3'd1, "R7 write");
    srcFlags[5] = 1'b1; cycle("R8 setup");
    writeSel(3'd6, "R8 switch");
    cycle("R8 pulse after switch");
    cycle("R4 after switch");

    // switch into free running with done already high
    doneFlag = 1'b1; cycle("R9 setup");
    writeSel(3'd0, "R9 switch");
    cycle("R9 no pulse");
    cycle("R9 still none");
    doneFlag = 1'b0; cycle("R9 low");
    doneFlag = 1'b1; cycle("R10 after switch");
    doneFlag = 1'b0; srcFlags = '0; cycle("R10 clear");

    // random mix
    for (int n = 0; n < 2000; n++) begin
      selWrite = ($urandom_range(0, 5) == 0);
      selData = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) srcFlags = 7'($urandom);
      if ($urandom_range(0, 2) == 0) doneFlag = 1'($urandom);
      autoEn = ($urandom_range(0, 7) != 0);
      convEn = ($urandom_range(0, 7) != 0);
      cycle("R3 R5 R6 R8 R9 R11 random");
    end
    selWrite = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule